// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a configuration bitstream into an FPGA through its slave-serial pins. A host pulses `start_i` with the total number of bytes it will supply, then streams those bytes over a valid/ready byte port. The loader resets the target with a low pulse on the program line and waits for the target to clear its configuration memory. It then confirms that the target's done line is low. Any header in front of the bitstream is discarded. The payload is serialised onto the data line, most significant bit first, with one configuration clock pulse per bit.

Once the stream is exhausted, the loader issues a short burst of extra configuration clocks and lets the target settle. It then reads the done line to decide the outcome. The result stays on `done_ok_o` and `err_o` until the next start. Every timing interval is a parameter counted in system clocks: the program pulse, the clear wait, the settle wait and each half-period of the configuration clock.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset, and whenever `busy_o` is low, the pins idle at program high, configuration clock low and data low. `byte_ready_o` is low in that state. Reset also clears `done_ok_o` and sets `err_o` to 0.
- R2: A start accepted while idle raises `busy_o` on the next cycle and drives the program line low for exactly PROG_CYC system clocks. While the program line is low, no configuration clock pulse occurs.
- R3: After the program line is released and CLEAR_CYC cycles have passed, a synchronised done level that reads high ends the run with `err_o` = 1. In that case no byte is accepted and no configuration clock pulse occurs.
- R4: Bytes that arrive before the first 0xFF byte are accepted and discarded. The 0xFF byte is the first byte shifted out, and every byte after it is shifted too. Header bytes count toward the length given at start. If the length runs out before a 0xFF byte arrives (a length of 0 included), the run ends with `err_o` = 2 and no clock pulse.
- R5: Each shifted byte produces eight configuration clock pulses, most significant bit first. Each high phase lasts exactly DIV system clocks and each low phase lasts at least DIV. The data line changes only while the configuration clock is low.
- R6: `byte_ready_o` is high only while the loader is searching for the 0xFF byte, or while the shifter is idle and bytes remain. It is never high while the configuration clock is high. Exactly the given number of bytes is accepted.
- R7: After the last data bit, exactly TAIL_CLKS (5) further clock pulses follow, with the data line held at the value of the last data bit.
- R8: SETTLE_CYC cycles after the trailing pulses, a synchronised done level of high ends the run with `done_ok_o` = 1 and `err_o` = 0. A low level ends it with `done_ok_o` = 0 and `err_o` = 3.
- R9: `done_ok_o` and `err_o` hold their values until the next accepted start. A start pulse while `busy_o` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (taken only while idle) |
| len_i | input | LEN_W | Total byte count, header included |
| byte_data_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte is valid |
| byte_ready_o | output | 1 | Loader accepts the byte this cycle |
| cfg_prog_o | output | 1 | Program line to the target, active low |
| cfg_cclk_o | output | 1 | Configuration clock to the target |
| cfg_din_o | output | 1 | Serial configuration data |
| cfg_done_i | input | 1 | Done line from the target (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| done_ok_o | output | 1 | Last load finished with done high |
| err_o | output | 2 | 0 none, 1 done high after clear, 2 no 0xFF byte, 3 done low at end |

## Verification
Most corruptions of internal state show up at the pins within one configuration clock period. A shift register that slips, or a bit counter that is off by one, sends a wrong bit or a wrong number of pulses before the next byte is accepted. The bench compares every captured bit and every pulse count against the arithmetic stream. A wrong remaining-byte count or a wrong state shows up at the end of the run, as a wrong handshake total or a wrong error code. Timer faults change the measured program pulse width or the high-phase width directly.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_CLEAR,
        ST_HUNT,
        ST_SHIFT,
        ST_TAIL,
        ST_SETTLE
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_DONE_HIGH = 2'd1,
        ERR_NO_SYNC   = 2'd2,
        ERR_DONE_LOW  = 2'd3
    } ld_err_e;

    // Pin bundle driven towards the target device.
    typedef struct packed {
        logic prog_n;
        logic cclk;
        logic din;
    } cfg_pins_t;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int width_for(input int v);
        return (v > 1) ? $clog2(v + 1) : 1;
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
    parameter int DIV       = 4,
    parameter int TAIL_CLKS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       tail_i,
    output logic       idle_o,
    output logic       cclk_o,
    output logic       din_o
);
    localparam int DW = cfgld_pkg::width_for(DIV);
    localparam int BW = cfgld_pkg::width_for((TAIL_CLKS > 8) ? TAIL_CLKS : 8);
    localparam logic [DW-1:0] TMR_LAST = DW'(DIV - 1);

    logic [7:0]    sh_q;
    logic [BW-1:0] left_q;
    logic [DW-1:0] tmr_q;
    logic          hi_q;
    logic          tail_q;
    logic          din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            tail_q <= 1'b0;
            din_q  <= 1'b0;
        end else if (load_i) begin
            sh_q   <= {byte_i[6:0], 1'b0};
            din_q  <= byte_i[7];
            left_q <= BW'(8);
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            tail_q <= 1'b0;
        end else if (tail_i) begin
            left_q <= BW'(TAIL_CLKS);
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            tail_q <= 1'b1;
        end else if (left_q != '0) begin
            if (tmr_q == TMR_LAST) begin
                tmr_q <= '0;
                if (!hi_q) begin
                    hi_q <= 1'b1;
                end else begin
                    hi_q   <= 1'b0;
                    left_q <= left_q - BW'(1);
                    // next bit goes out only while the clock is back low
                    if (!tail_q && left_q != BW'(1)) begin
                        din_q <= sh_q[7];
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                tmr_q <= tmr_q + DW'(1);
            end
        end
    end

    assign idle_o = (left_q == '0);
    assign cclk_o = hi_q;
    assign din_o  = din_q;
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PROG_CYC   = 4,
    parameter int CLEAR_CYC  = 50,
    parameter int SETTLE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    input  logic             done_s_i,
    input  logic             sh_idle_i,
    output logic             byte_ready_o,
    output logic             load_o,
    output logic             tail_o,
    output logic             prog_n_o,
    output logic             din_en_o,
    output logic             busy_o,
    output logic             done_ok_o,
    output ld_err_e          err_o
);
    localparam int CW = width_for(max3(PROG_CYC, CLEAR_CYC, SETTLE_CYC));

    ld_state_e        state_q;
    logic [CW-1:0]    cnt_q;
    logic [LEN_W-1:0] rem_q;
    logic             ok_q;
    ld_err_e          err_q;
    logic             hs;
    logic             have_bytes;

    assign have_bytes   = (rem_q != '0);
    assign byte_ready_o = have_bytes &&
                          ((state_q == ST_HUNT) || (state_q == ST_SHIFT && sh_idle_i));
    assign hs           = byte_valid_i && byte_ready_o;
    assign load_o       = hs && ((state_q == ST_SHIFT) || (byte_i == SYNC_BYTE));
    assign tail_o       = (state_q == ST_SHIFT) && sh_idle_i && !have_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            ok_q    <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_PROG;
                    cnt_q   <= '0;
                    rem_q   <= len_i;
                    ok_q    <= 1'b0;
                    err_q   <= ERR_NONE;
                end
                ST_PROG: if (cnt_q == CW'(PROG_CYC - 1)) begin
                    state_q <= ST_CLEAR;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
                ST_CLEAR: if (cnt_q == CW'(CLEAR_CYC - 1)) begin
                    cnt_q <= '0;
                    if (done_s_i) begin
                        err_q   <= ERR_DONE_HIGH;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_HUNT;
                    end
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
                ST_HUNT: if (!have_bytes) begin
                    err_q   <= ERR_NO_SYNC;
                    state_q <= ST_IDLE;
                end else if (hs) begin
                    rem_q <= rem_q - LEN_W'(1);
                    if (byte_i == SYNC_BYTE) state_q <= ST_SHIFT;
                end
                ST_SHIFT: if (hs) begin
                    rem_q <= rem_q - LEN_W'(1);
                end else if (tail_o) begin
                    state_q <= ST_TAIL;
                end
                ST_TAIL: if (sh_idle_i) begin
                    state_q <= ST_SETTLE;
                    cnt_q   <= '0;
                end
                ST_SETTLE: if (cnt_q == CW'(SETTLE_CYC - 1)) begin
                    state_q <= ST_IDLE;
                    if (done_s_i) ok_q  <= 1'b1;
                    else          err_q <= ERR_DONE_LOW;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign prog_n_o  = (state_q != ST_PROG);
    assign din_en_o  = (state_q == ST_SHIFT) || (state_q == ST_TAIL) || (state_q == ST_SETTLE);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_ok_o = ok_q;
    assign err_o     = err_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int DIV         = 4,
    parameter int PROG_CYC    = 4,
    parameter int CLEAR_CYC   = 50,
    parameter int SETTLE_CYC  = 100,
    parameter int TAIL_CLKS   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             cfg_prog_o,
    output logic             cfg_cclk_o,
    output logic             cfg_din_o,
    input  logic             cfg_done_i,
    output logic             busy_o,
    output logic             done_ok_o,
    output logic [1:0]       err_o
);
    logic      done_s;
    logic      sh_idle, sh_cclk, sh_din;
    logic      load, tail, prog_n, din_en;
    ld_err_e   err;
    cfg_pins_t pins;

    cfgld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cfg_done_i),
        .sync_o  (done_s)
    );

    cfgld_ctrl #(
        .LEN_W      (LEN_W),
        .PROG_CYC   (PROG_CYC),
        .CLEAR_CYC  (CLEAR_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .len_i        (len_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_data_i),
        .done_s_i     (done_s),
        .sh_idle_i    (sh_idle),
        .byte_ready_o (byte_ready_o),
        .load_o       (load),
        .tail_o       (tail),
        .prog_n_o     (prog_n),
        .din_en_o     (din_en),
        .busy_o       (busy_o),
        .done_ok_o    (done_ok_o),
        .err_o        (err)
    );

    cfgld_shifter #(.DIV(DIV), .TAIL_CLKS(TAIL_CLKS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .byte_i (byte_data_i),
        .tail_i (tail),
        .idle_o (sh_idle),
        .cclk_o (sh_cclk),
        .din_o  (sh_din)
    );

    always_comb begin
        pins.prog_n = prog_n;
        pins.cclk   = sh_cclk;
        pins.din    = sh_din & din_en;
    end

    assign cfg_prog_o = pins.prog_n;
    assign cfg_cclk_o = pins.cclk;
    assign cfg_din_o  = pins.din;
    assign err_o      = err;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       byte_ready_o,
    input logic       cfg_prog_o,
    input logic       cfg_cclk_o,
    input logic       cfg_din_o,
    input logic       busy_o,
    input logic       done_ok_o,
    input logic [1:0] err_o
);
    int hi_run;

    always_ff @(posedge clk) begin
        if (rst || !cfg_cclk_o) hi_run <= 0;
        else                    hi_run <= hi_run + 1;
    end

    // R5: a high phase never outlasts DIV cycles
    always @(negedge clk) begin
        if (!rst) p_cclk_width_r5: assert (hi_run <= DIV);
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cfg_prog_o && !cfg_cclk_o && !cfg_din_o && !byte_ready_o));

    p_prog_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_o |-> (!cfg_cclk_o && !byte_ready_o));

    p_din_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_cclk_o && $past(cfg_cclk_o)) |-> $stable(cfg_din_o));

    p_ready_clk_low_r6: assert property (@(posedge clk) disable iff (rst)
        byte_ready_o |-> !cfg_cclk_o);

    p_ok_no_err_r8: assert property (@(posedge clk) disable iff (rst)
        done_ok_o |-> (err_o == 2'd0));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(done_ok_o)));
endmodule

bind serial_cfg_loader cfgld_checker #(.DIV(DIV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_ready_o (byte_ready_o),
    .cfg_prog_o   (cfg_prog_o),
    .cfg_cclk_o   (cfg_cclk_o),
    .cfg_din_o    (cfg_din_o),
    .busy_o       (busy_o),
    .done_ok_o    (done_ok_o),
    .err_o        (err_o)
);

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;
    localparam int LEN_W  = 16;
    localparam int DIV    = 2;
    localparam int PROG   = 3;
    localparam int CLEAR  = 50;
    localparam int SETTLE = 100;
    localparam int TAIL   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [7:0] byte_data_i = '0;
    logic byte_valid_i = 1'b0;
    logic cfg_done_i = 1'b0;
    logic byte_ready_o, cfg_prog_o, cfg_cclk_o, cfg_din_o, busy_o, done_ok_o;
    logic [1:0] err_o;

    always #2.5 clk = ~clk;

    serial_cfg_loader #(
        .LEN_W(LEN_W), .DIV(DIV), .PROG_CYC(PROG), .CLEAR_CYC(CLEAR),
        .SETTLE_CYC(SETTLE), .TAIL_CLKS(TAIL), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
        .byte_ready_o(byte_ready_o), .cfg_prog_o(cfg_prog_o),
        .cfg_cclk_o(cfg_cclk_o), .cfg_din_o(cfg_din_o), .cfg_done_i(cfg_done_i),
        .busy_o(busy_o), .done_ok_o(done_ok_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // pin monitor, sampled away from the active edge
    int   pulses = 0;
    int   prog_lo = 0;
    int   hi_len = 0;
    int   lo_len = 100;
    int   width_bad = 0;
    int   rdy_bad = 0;
    int   din_bad = 0;
    logic prev_cclk = 1'b0;
    logic prev_din = 1'b0;
    logic bitlog [0:4095];

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!rst) begin
            if (!cfg_prog_o) prog_lo <= prog_lo + 1;
            if (byte_ready_o && cfg_cclk_o) rdy_bad <= rdy_bad + 1;
            if (cfg_cclk_o && prev_cclk && cfg_din_o != prev_din) din_bad <= din_bad + 1;
            if (cfg_cclk_o && !prev_cclk) begin
                bitlog[pulses % 4096] <= cfg_din_o;
                pulses <= pulses + 1;
                if (lo_len < DIV) width_bad <= width_bad + 1;
            end
            if (cfg_cclk_o) begin
                hi_len <= (prev_cclk ? hi_len : 0) + 1;
                lo_len <= 0;
            end else begin
                if (prev_cclk && hi_len != DIV) width_bad <= width_bad + 1;
                lo_len <= lo_len + 1;
            end
            prev_cclk <= cfg_cclk_o;
            prev_din  <= cfg_din_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int k, input int hdr);
        if (k < hdr)       return 8'((k * 37 + 5) & 8'h7F);
        else if (k == hdr) return 8'hFF;
        else               return 8'((k * 53 + 11 + hdr * 7) & 8'hFF);
    endfunction

    int hs_cnt = 0;

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid_i = 1'b1;
        byte_data_i  = b;
        while (!byte_ready_o) @(negedge clk);
        @(posedge clk);
        hs_cnt++;
        #1;
        byte_valid_i = 1'b0;
    endtask

    task automatic do_run(input int hdr, input int pay, input bit no_sync,
                          input bit stuck_hi, input bit end_hi, input bit poke);
        int n, exp_p, base_p, base_prog, base_hs, nbits, mism, tail_bad, exp_err;
        logic [7:0] lastb;
        n = no_sync ? hdr : hdr + 1 + pay;
        exp_p = (no_sync || stuck_hi) ? 0 : 8 * (pay + 1) + TAIL;
        base_p = pulses; base_prog = prog_lo; base_hs = hs_cnt;
        cfg_done_i = stuck_hi;
        @(negedge clk);
        start_i = 1'b1; len_i = LEN_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        fork
            begin
                if (!stuck_hi)
                    for (int k = 0; k < n; k++) send(byte_of(k, hdr));
            end
            begin
                if (exp_p != 0) begin
                    wait (pulses - base_p == exp_p);
                    cfg_done_i = end_hi;
                end
            end
            begin
                if (poke) begin
                    repeat (70) @(negedge clk);
                    start_i = 1'b1; len_i = LEN_W'(1);
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
        join
        while (busy_o) @(negedge clk);
        exp_err = stuck_hi ? 1 : no_sync ? 2 : end_hi ? 0 : 3;
        chk(err_o == 2'(exp_err), "R3/R4/R8 error code", int'(err_o), exp_err);
        chk(done_ok_o == (exp_err == 0), "R8 done_ok", int'(done_ok_o), int'(exp_err == 0));
        chk(prog_lo - base_prog == PROG, "R2 program pulse width", prog_lo - base_prog, PROG);
        chk(pulses - base_p == exp_p, "R5/R7 clock pulse count", pulses - base_p, exp_p);
        chk(hs_cnt - base_hs == (stuck_hi ? 0 : n), "R6 bytes accepted",
            hs_cnt - base_hs, stuck_hi ? 0 : n);
        if (exp_p != 0) begin
            nbits = 8 * (pay + 1);
            mism = 0;
            for (int i = 0; i < nbits; i++) begin
                logic [7:0] b;
                b = byte_of(hdr + i / 8, hdr);
                if (bitlog[(base_p + i) % 4096] != b[7 - i % 8]) mism++;
            end
            chk(mism == 0, "R4/R5 shifted bits MSB first from 0xFF", mism, 0);
            lastb = byte_of(hdr + pay, hdr);
            tail_bad = 0;
            for (int i = 0; i < TAIL; i++)
                if (bitlog[(base_p + nbits + i) % 4096] != lastb[0]) tail_bad++;
            chk(tail_bad == 0, "R7 data held in trailing pulses", tail_bad, 0);
        end
        repeat (20) @(negedge clk);
        chk(err_o == 2'(exp_err) && done_ok_o == (exp_err == 0), "R9 status held",
            int'(err_o), exp_err);
        chk(cfg_prog_o && !cfg_cclk_o && !cfg_din_o && !byte_ready_o, "R1 idle pins",
            int'({cfg_prog_o, cfg_cclk_o, cfg_din_o, byte_ready_o}), 8);
        cfg_done_i = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_prog_o && !cfg_cclk_o && !cfg_din_o && !byte_ready_o && !busy_o,
            "R1 reset pins", int'({cfg_prog_o, cfg_cclk_o, cfg_din_o, byte_ready_o, busy_o}), 16);
        chk(err_o == 2'd0 && !done_ok_o, "R1 reset status", int'(err_o), 0);
        // sweep header length against payload length
        for (int h = 0; h < 4; h++)
            for (int p = 0; p < 3; p++)
                do_run(h, p, 1'b0, 1'b0, 1'b1, 1'b0);
        do_run(0, 0, 1'b0, 1'b1, 1'b1, 1'b0);   // R3 done stuck high
        do_run(3, 0, 1'b1, 1'b0, 1'b1, 1'b0);   // R4 no sync byte
        do_run(0, 0, 1'b1, 1'b0, 1'b1, 1'b0);   // R4 zero length
        do_run(2, 2, 1'b0, 1'b0, 1'b0, 1'b0);   // R8 done low at end
        do_run(1, 4, 1'b0, 1'b0, 1'b1, 1'b1);   // R9 start while busy
        chk(width_bad == 0, "R5 clock phase widths", width_bad, 0);
        chk(din_bad == 0, "R5 data stable while clock high", din_bad, 0);
        chk(rdy_bad == 0, "R6 ready never with clock high", rdy_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule